// File: doc/BRIEF.md
# Reference-Curve Progress Tracker

This block follows a periodic application through a stored tree of reference curve segments. Once per sample tick (one 100 µs period, after which the event counters restart from zero) it receives four event counts: instructions completed, branches completed, stores completed and bus interface accesses. It compares that vector with the centroid of each child of the node it currently sits on. For each child it counts the elements whose absolute difference from the centroid exceeds a programmable limit. It then moves to the best-matching child if that child matches well enough.

Alongside the walk it keeps two tick counters. One counts the ticks elapsed since the period began. The other counts the reference ticks, which is the number of tree steps actually taken. A slowed application stretches its curve in time, so it needs more ticks than the reference to reach the same node. From the two counters the block derives a fixed-point slowdown figure. A period-start input returns the walk to the root, node 0, which marks the beginning of an application period. The tree is loaded one node at a time through a plain write port.

Top module: `prog_tracker`

## Requirements
- R1: After reset, cur_node is 0, slowdown is 0 and every tree node is a leaf (child count 0).
- R2: A cycle with cfg_we high stores, for node cfg_addr, the centroid cfg_centroid, the first child index cfg_first and the child count cfg_nchild. The children of a node are nodes cfg_first .. cfg_first+cfg_nchild-1, and at most MAX_CHILD (4) of them are examined.
- R3: An element counts as a mismatch only when the absolute difference between sample and centroid is strictly greater than elem_limit. A difference equal to the limit is not a mismatch. Element i of sample_vec and cfg_centroid occupies bits [16i+15:16i], in the order instructions, branches, stores, bus accesses.
- R4: The candidate with the fewest mismatches is chosen, and on a tie the lowest child index wins.
- R5: The tracker advances to the chosen child only when its mismatch count is less than or equal to accept_bound. Otherwise, or when the current node is a leaf, cur_node is unchanged.
- R6: cur_node takes its new value at the same clock edge that samples sample_valid high, and it changes at no other time except on reset and period start.
- R7: Each accepted sample adds one to the elapsed tick count (saturating). Each advance also adds one to the reference tick count, so the elapsed count never falls below the reference count.
- R8: slowdown equals floor((E-R)*200/R) in units of 0.5 %, saturated at 31, where E is the elapsed count and R is the reference count. It is 0 when E equals R and 31 when R is 0 and E is greater than 0. It is registered one clock after the counters change.
- R9: period_start returns cur_node to 0 and clears both tick counters, and it takes priority over a sample arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Tree node write strobe |
| cfg_addr | input | 4 | Node index being written |
| cfg_centroid | input | 64 | Four 16-bit reference counts for the node |
| cfg_first | input | 4 | Index of the node's first child |
| cfg_nchild | input | 3 | Number of children (0 = leaf) |
| elem_limit | input | 16 | Per-element difference limit |
| accept_bound | input | 3 | Largest mismatch count that still allows an advance |
| period_start | input | 1 | Restart tracking at the root |
| sample_valid | input | 1 | A sample vector is present this cycle |
| sample_vec | input | 64 | Four 16-bit event counts |
| cur_node | output | 4 | Node currently tracked |
| slowdown | output | 5 | Slowdown estimate, 0.5 % per unit |

## Verification
A sample or a period start presented before edge N is reflected in cur_node just after edge N. The slowdown figure derived from it appears one edge later, at N+1. Each scenario task drives inputs on the falling edge and reads cur_node on the next falling edge. It then waits one more falling edge before comparing slowdown against a value computed in the bench from that test's own tally of elapsed and advanced ticks. This keeps every sample away from the edge on which the value is still being written.

// File: rtl/trk_pkg.sv
package trk_pkg;
    localparam int NUM_CTR   = 4;
    localparam int CNT_W     = 16;
    localparam int NODES     = 16;
    localparam int MAX_CHILD = 4;
    localparam int TICK_W    = 16;
    localparam int SLOW_W    = 5;
    localparam int SLOW_MAX  = (1 << SLOW_W) - 1;
    localparam int SCALE     = 200;
    localparam int SCALE_W   = 8;

    localparam int IDX_W  = $clog2(NODES);
    localparam int CHN_W  = $clog2(MAX_CHILD + 1);
    localparam int MCNT_W = $clog2(NUM_CTR + 2);
    localparam int VEC_W  = NUM_CTR * CNT_W;

    typedef logic [NUM_CTR-1:0][CNT_W-1:0] vec_t;

    typedef struct packed {
        vec_t             cent;
        logic [IDX_W-1:0] first;
        logic [CHN_W-1:0] nchild;
    } node_t;

    function automatic logic [MCNT_W-1:0] miss_count(
        input vec_t a, input vec_t b, input logic [CNT_W-1:0] lim);
        logic [MCNT_W-1:0] n;
        logic [CNT_W-1:0]  d;
        n = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            d = (a[i] > b[i]) ? (a[i] - b[i]) : (b[i] - a[i]);
            if (d > lim) n = n + 1'b1;
        end
        return n;
    endfunction
endpackage

// File: rtl/trk_node_store.sv
module trk_node_store
    import trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  node_t            wdata,
    input  logic [IDX_W-1:0] cur_idx,
    output node_t            cur_rec,
    output node_t            child_rec [MAX_CHILD],
    output logic [IDX_W-1:0] child_idx [MAX_CHILD]
);
    node_t mem [NODES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NODES; n++) mem[n] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign cur_rec = mem[cur_idx];

    for (genvar k = 0; k < MAX_CHILD; k++) begin : g_child
        assign child_idx[k] = cur_rec.first + IDX_W'(k);
        assign child_rec[k] = mem[child_idx[k]];
    end
endmodule

// File: rtl/trk_child_select.sv
module trk_child_select
    import trk_pkg::*;
(
    input  vec_t              sample,
    input  logic [CNT_W-1:0]  limit,
    input  logic [MCNT_W-1:0] bound,
    input  logic [CHN_W-1:0]  nchild,
    input  node_t             child_rec [MAX_CHILD],
    input  logic [IDX_W-1:0]  child_idx [MAX_CHILD],
    output logic              advance,
    output logic [IDX_W-1:0]  next_idx
);
    logic [MCNT_W-1:0] cnt [MAX_CHILD];
    logic              present [MAX_CHILD];

    for (genvar k = 0; k < MAX_CHILD; k++) begin : g_cmp
        assign present[k] = (CHN_W'(k) < nchild);
        assign cnt[k]     = miss_count(sample, child_rec[k].cent, limit);
    end

    logic [MCNT_W-1:0] best_cnt;
    logic              found;

    always_comb begin
        best_cnt = '1;
        next_idx = '0;
        found    = 1'b0;
        for (int k = 0; k < MAX_CHILD; k++) begin
            if (present[k] && (!found || cnt[k] < best_cnt)) begin
                best_cnt = cnt[k];
                next_idx = child_idx[k];
                found    = 1'b1;
            end
        end
        advance = found && (best_cnt <= bound);
    end
endmodule

// File: rtl/trk_slowdown.sv
module trk_slowdown
    import trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] elapsed,
    input  logic [TICK_W-1:0] refcnt,
    output logic [SLOW_W-1:0] slowdown
);
    localparam int NW = TICK_W + SCALE_W;

    logic [TICK_W-1:0] diff;
    logic [NW-1:0]     num;
    logic [NW-1:0]     den;
    logic [NW-1:0]     rem;
    logic [SLOW_W-1:0] q;

    assign diff = elapsed - refcnt;
    assign num  = NW'(diff) * NW'(SCALE);
    assign den  = NW'(refcnt);

    always_comb begin
        rem = num;
        q   = '0;
        if (diff == '0) begin
            q = '0;
        end else if (num >= (den << SLOW_W)) begin
            q = SLOW_W'(SLOW_MAX);
        end else begin
            for (int b = SLOW_W - 1; b >= 0; b--) begin
                if (rem >= (den << b)) begin
                    rem  = rem - (den << b);
                    q[b] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slowdown <= '0;
        else     slowdown <= q;
    end
endmodule

// File: rtl/prog_tracker.sv
module prog_tracker
    import trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [VEC_W-1:0]  cfg_centroid,
    input  logic [IDX_W-1:0]  cfg_first,
    input  logic [CHN_W-1:0]  cfg_nchild,
    input  logic [CNT_W-1:0]  elem_limit,
    input  logic [MCNT_W-1:0] accept_bound,
    input  logic              period_start,
    input  logic              sample_valid,
    input  logic [VEC_W-1:0]  sample_vec,
    output logic [IDX_W-1:0]  cur_node,
    output logic [SLOW_W-1:0] slowdown
);
    node_t             wrec;
    node_t             cur_rec;
    node_t             child_rec [MAX_CHILD];
    logic [IDX_W-1:0]  child_idx [MAX_CHILD];
    logic              adv;
    logic [IDX_W-1:0]  nxt;
    logic [TICK_W-1:0] elapsed_q;
    logic [TICK_W-1:0] refcnt_q;
    logic [CHN_W-1:0]  cur_nchild;

    assign wrec.cent   = vec_t'(cfg_centroid);
    assign wrec.first  = cfg_first;
    assign wrec.nchild = cfg_nchild;
    assign cur_nchild  = cur_rec.nchild;

    trk_node_store u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .waddr     (cfg_addr),
        .wdata     (wrec),
        .cur_idx   (cur_node),
        .cur_rec   (cur_rec),
        .child_rec (child_rec),
        .child_idx (child_idx)
    );

    trk_child_select u_sel (
        .sample    (vec_t'(sample_vec)),
        .limit     (elem_limit),
        .bound     (accept_bound),
        .nchild    (cur_rec.nchild),
        .child_rec (child_rec),
        .child_idx (child_idx),
        .advance   (adv),
        .next_idx  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || period_start) begin
            cur_node  <= '0;
            elapsed_q <= '0;
            refcnt_q  <= '0;
        end else if (sample_valid) begin
            if (elapsed_q != '1) elapsed_q <= elapsed_q + 1'b1;
            if (adv) begin
                cur_node <= nxt;
                if (refcnt_q != '1) refcnt_q <= refcnt_q + 1'b1;
            end
        end
    end

    trk_slowdown u_slow (
        .clk      (clk),
        .rst      (rst),
        .elapsed  (elapsed_q),
        .refcnt   (refcnt_q),
        .slowdown (slowdown)
    );
endmodule

// File: rtl/trk_checker.sv
module trk_checker
    import trk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sample_valid,
    input logic              period_start,
    input logic [IDX_W-1:0]  cur_node,
    input logic [SLOW_W-1:0] slowdown,
    input logic [CHN_W-1:0]  cur_nchild,
    input logic [TICK_W-1:0] elapsed,
    input logic [TICK_W-1:0] refcnt
);
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !period_start) |=> $stable(cur_node));

    assert_leaf_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !period_start && cur_nchild == '0) |=> $stable(cur_node));

    assert_root_R9: assert property (@(posedge clk) disable iff (rst)
        period_start |=> (cur_node == '0 && elapsed == '0 && refcnt == '0));

    assert_zero_R8: assert property (@(posedge clk) disable iff (rst)
        period_start |=> ##1 (slowdown == '0));

    assert_order_R7: assert property (@(posedge clk) disable iff (rst)
        elapsed >= refcnt);

    assert_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !period_start && elapsed != '1) |=> elapsed == $past(elapsed) + 1'b1);
endmodule

bind prog_tracker trk_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .period_start (period_start),
    .cur_node     (cur_node),
    .slowdown     (slowdown),
    .cur_nchild   (cur_nchild),
    .elapsed      (elapsed_q),
    .refcnt       (refcnt_q)
);

// File: tb/sim_prog_tracker.sv
module sim_prog_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [63:0] cfg_centroid = '0;
    logic [3:0]  cfg_first = '0;
    logic [2:0]  cfg_nchild = '0;
    logic [15:0] elem_limit = 16'd10;
    logic [2:0]  accept_bound = 3'd1;
    logic        period_start = 1'b0;
    logic        sample_valid = 1'b0;
    logic [63:0] sample_vec = '0;
    logic [3:0]  cur_node;
    logic [4:0]  slowdown;

    int total = 0;
    int bad = 0;
    int el = 0;
    int rf = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prog_tracker u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_centroid(cfg_centroid), .cfg_first(cfg_first), .cfg_nchild(cfg_nchild),
        .elem_limit(elem_limit), .accept_bound(accept_bound),
        .period_start(period_start), .sample_valid(sample_valid),
        .sample_vec(sample_vec), .cur_node(cur_node), .slowdown(slowdown)
    );

    function automatic logic [63:0] vec4(int a, int b, int c, int d);
        return {16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    function automatic int exp_slow(int e, int r);
        int q;
        if (e == r) return 0;
        if (r == 0) return 31;
        q = ((e - r) * 200) / r;
        return (q > 31) ? 31 : q;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_node(int idx, int c, int first, int n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_centroid = vec4(c, c, c, c);
        cfg_first = 4'(first); cfg_nchild = 3'(n);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        el = 0; rf = 0;
    endtask

    // One sample; node checked one edge later, slowdown one edge after that.
    task automatic tick(logic [63:0] v, int exp_node, bit exp_adv, string req);
        @(negedge clk);
        sample_valid = 1'b1; sample_vec = v;
        @(negedge clk);
        sample_valid = 1'b0;
        el++; if (exp_adv) rf++;
        check(req, cur_node, exp_node);
        @(negedge clk);
        check("R8", slowdown, exp_slow(el, rf));
    endtask

    task automatic t_reset();
        check("R1 node", cur_node, 0);
        check("R1 slow", slowdown, 0);
        tick(vec4(0, 0, 0, 0), 0, 1'b0, "R1 leaf root");
    endtask

    task automatic t_load();
        write_node(0, 0, 1, 3);
        write_node(1, 100, 4, 1);
        write_node(2, 200, 0, 0);
        write_node(3, 200, 0, 0);
        for (int k = 4; k < 15; k++) write_node(k, k * 100, k + 1, 1);
        write_node(15, 1500, 0, 0);
    endtask

    task automatic t_tie();
        restart();
        tick(vec4(200, 200, 200, 200), 2, 1'b1, "R4 tie lowest");
    endtask

    task automatic t_limit();
        restart();
        tick(vec4(111, 111, 100, 100), 0, 1'b0, "R3 over limit");
        tick(vec4(110, 110, 110, 90), 1, 1'b1, "R3 equal limit");
        tick(vec4(400, 400, 400, 420), 4, 1'b1, "R5 at bound");
        tick(vec4(500, 500, 520, 520), 4, 1'b0, "R5 above bound");
    endtask

    task automatic t_slow();
        restart();
        tick(vec4(100, 100, 100, 100), 1, 1'b1, "R7 walk");
        for (int k = 4; k <= 12; k++) tick(vec4(k*100, k*100, k*100, k*100), k, 1'b1, "R7 walk");
        tick(vec4(0, 0, 0, 0), 12, 1'b0, "R7 stall");
        tick(vec4(1300, 1300, 1300, 1300), 13, 1'b1, "R7 step");
        tick(vec4(0, 0, 0, 0), 13, 1'b0, "R7 stall");
        tick(vec4(0, 0, 0, 0), 13, 1'b0, "R7 stall");
        tick(vec4(1400, 1400, 1400, 1400), 14, 1'b1, "R6 step");
        tick(vec4(1500, 1500, 1500, 1500), 15, 1'b1, "R6 step");
        tick(vec4(1500, 1500, 1500, 1500), 15, 1'b0, "R5 leaf");
    endtask

    task automatic t_priority();
        @(negedge clk);
        period_start = 1'b1; sample_valid = 1'b1; sample_vec = vec4(100, 100, 100, 100);
        @(negedge clk);
        period_start = 1'b0; sample_valid = 1'b0;
        check("R9 root", cur_node, 0);
        @(negedge clk);
        check("R9 slow", slowdown, 0);
        el = 0; rf = 0;
        tick(vec4(100, 100, 100, 100), 1, 1'b1, "R9 fresh walk");
    endtask

    task automatic t_rewrite();
        write_node(3, 300, 0, 0);
        restart();
        tick(vec4(300, 300, 300, 300), 3, 1'b1, "R2 rewrite");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_tie();
        t_limit();
        t_slow();
        t_priority();
        t_rewrite();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule